// File: doc/BRIEF.md
# Multiplexed-Address Flash Bus Interface

This block is the device-side front end of a byte-wide flash memory when the memory is driven through a narrow, multiplexed address port. This port is typically used by programming equipment on a production line. An external agent presents the high part of a byte address on an 11-bit address bus and then the low part, marking each part with a single row/column strobe. It then uses the output-enable, write-enable and reset-pin controls to run read cycles, write cycles, output-disable periods and resets.

Read cycles take a byte from an array port, which may return array, signature or status data, and drive it onto the 8-bit data bus. Write cycles pass the captured byte and the current address to a command-interface port. Every command is forwarded unfiltered. The command state machine, the array and the program/erase timing sit outside the block and reach it through simple ports.

A reset-pin pulse counts only once it has been held for a minimum width. If a valid reset arrives during a program or erase, the block aborts that operation. It holds busy for a bounded abort time and raises a sticky invalid-data flag for the address that was being worked on. In this mode no block can be locked.

Top module: `mux_flash_bus_if`

## Requirements
- R1: A falling edge of `rowcol_sel` latches all 11 address pins as the row part. A rising edge latches pins [7:0] as the column part. `rd_addr` = {row, column} (19 bits) and changes one clock after the edge is sampled. Edges are ignored while `rp_n` is low.
- R2: When `rp_n`=1, `we_n`=1 and `oe_n`=0 have been sampled at a clock edge and still hold, `dq_drive`=1. In that case, `dq_out` carries the `rd_data` byte that was returned for the address in effect at that edge.
- R3: Whenever `oe_n`=1, `dq_drive`=0 in the same cycle.
- R4: Whenever `rp_n`=0, `dq_drive`=0 in the same cycle.
- R5: A rising edge of `we_n` sampled with `rp_n`=1 gives a one-cycle `cmd_wr_valid` pulse. The pulse carries the `dq_in` byte sampled at the last clock with `we_n` low and the address in effect at the edge.
- R6: With `we_n`=0 and `oe_n`=0 together, the cycle counts as a write and `dq_drive` stays 0.
- R7: A reset counts as valid at the clock edge where `rp_n` has been sampled low for RST_MIN_CYC consecutive edges. A shorter low pulse has no effect on address, busy or flags.
- R8: A valid reset while `core_busy`=1 gives a one-cycle `abort_pulse`. After it, `dev_busy` stays 1 for ABORT_CYC cycles. `dev_busy` is `core_busy` OR an abort in progress.
- R9: An abort sets `inval_flag` and captures `core_op_addr` into `inval_addr`. Both are sticky.
- R10: `inval_flag` clears one clock after `core_done`=1 is sampled with no abort in progress. If a setting abort happens at the same edge, the set wins.
- R11: `blk_locked` is 0 at all times, whatever commands are written.
- R12: A valid reset clears the row and column parts to zero. A reset without `core_busy` gives no `abort_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| addr_pin | input | 11 | Multiplexed address pins |
| rowcol_sel | input | 1 | Row/column strobe (fall = row, rise = column) |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rp_n | input | 1 | Interface reset pin, active low |
| dq_in | input | 8 | Data bus as seen at the pins |
| dq_out | output | 8 | Data driven onto the bus |
| dq_drive | output | 1 | Bus driver enable (0 = high-impedance) |
| rd_addr | output | 19 | Current byte address to the array port |
| rd_data | input | 8 | Byte returned for `rd_addr` |
| cmd_wr_valid | output | 1 | One-cycle write to the command interface |
| cmd_wr_addr | output | 19 | Address of the write |
| cmd_wr_data | output | 8 | Data of the write |
| core_busy | input | 1 | Program or erase in progress |
| core_done | input | 1 | Program or erase completed successfully |
| core_op_addr | input | 19 | Address the running operation affects |
| abort_pulse | output | 1 | One-cycle abort request to the core |
| dev_busy | output | 1 | Busy, including abort time |
| inval_flag | output | 1 | Sticky invalid-data flag |
| inval_addr | output | 19 | Address range marked invalid |
| blk_locked | output | 1 | Block protection state (always 0 here) |

## Verification
Two functions can land on the same clock edge. The first pair is a reset reaching its valid width and `core_done` arriving while `core_busy` is high. The bench raises both together at the edge where the reset becomes valid and expects the invalid flag to be set, not cleared. The second pair is a write-enable rising edge and a row-strobe falling edge. The bench releases `we_n` and drops `rowcol_sel` together and expects the forwarded write to carry the old address, while `rd_addr` moves to the new row one clock later. A behavioural model in the bench predicts every output on each clock and judges both cases.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_RESET = 2'd3
  } mfb_cycle_e;
endpackage

// File: rtl/mfb_rst_sync.sv
module mfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mfb_addr_latch.sv
module mfb_addr_latch #(
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  localparam int AW = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rowcol_sel,
  input  logic [ROW_W-1:0] addr_pin,
  input  logic             pin_en,
  input  logic             clr,
  output logic [AW-1:0]    byte_addr
);
  logic             rc_q, rc_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             rc_fall, rc_rise;

  assign rc_fall = rc_q & ~rowcol_sel & pin_en;
  assign rc_rise = ~rc_q & rowcol_sel & pin_en;

  always_comb begin
    rc_d  = rowcol_sel;
    row_d = row_q;
    col_d = col_q;
    if (clr) begin
      row_d = '0;
      col_d = '0;
    end else begin
      if (rc_fall) row_d = addr_pin;
      if (rc_rise) col_d = addr_pin[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q  <= 1'b1;
      row_q <= '0;
      col_q <= '0;
    end else begin
      rc_q  <= rc_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign byte_addr = {row_q, col_q};
endmodule

// File: rtl/mfb_cycle_decode.sv
module mfb_cycle_decode
  import mfb_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rp_n,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [AW-1:0]     byte_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  mfb_cycle_e        cyc;
  logic              we_q, we_d;
  logic              rd_q, rd_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              wv_q, wv_d;
  logic [AW-1:0]     wa_q, wa_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              we_rise;

  always_comb begin
    if (!rp_n)      cyc = CYC_RESET;
    else if (!we_n) cyc = CYC_WRITE;
    else if (!oe_n) cyc = CYC_READ;
    else            cyc = CYC_IDLE;
  end

  assign we_rise = ~we_q & we_n & rp_n;

  always_comb begin
    we_d   = we_n;
    rd_d   = (cyc == CYC_READ);
    dout_d = rd_data;
    hold_d = (cyc == CYC_WRITE) ? dq_in : hold_q;
    wv_d   = we_rise;
    wa_d   = we_rise ? byte_addr : wa_q;
    wd_d   = we_rise ? hold_q : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      rd_q   <= 1'b0;
      dout_q <= '0;
      hold_q <= '0;
      wv_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      we_q   <= we_d;
      rd_q   <= rd_d;
      dout_q <= dout_d;
      hold_q <= hold_d;
      wv_q   <= wv_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  // bus is released at once by the pins, the data itself is registered
  assign dq_drive = rd_q & (cyc == CYC_READ);
  assign dq_out   = dout_q;
  assign wr_valid = wv_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
endmodule

// File: rtl/mfb_abort_ctl.sv
module mfb_abort_ctl #(
  parameter int AW          = 19,
  parameter int RST_MIN_CYC = 4,
  parameter int ABORT_CYC   = 20,
  localparam int RCW = $clog2(RST_MIN_CYC + 1),
  localparam int ACW = $clog2(ABORT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_n,
  input  logic          core_busy,
  input  logic          core_done,
  input  logic [AW-1:0] core_op_addr,
  output logic          rst_hit,
  output logic          abort_pulse,
  output logic          dev_busy,
  output logic          inval_flag,
  output logic [AW-1:0] inval_addr
);
  localparam logic [RCW-1:0] RMIN    = RCW'(RST_MIN_CYC);
  localparam logic [RCW-1:0] RHIT    = RCW'(RST_MIN_CYC - 1);
  localparam logic [ACW-1:0] ABT_LEN = ACW'(ABORT_CYC);

  logic [RCW-1:0] lo_cnt_q, lo_cnt_d;
  logic [ACW-1:0] abt_cnt_q, abt_cnt_d;
  logic           abt_p_q, abt_p_d;
  logic           inv_q, inv_d;
  logic [AW-1:0]  inv_a_q, inv_a_d;
  logic           do_abort;

  assign rst_hit  = ~rp_n & (lo_cnt_q == RHIT);
  assign do_abort = rst_hit & core_busy;

  always_comb begin
    if (rp_n)                lo_cnt_d = '0;
    else if (lo_cnt_q != RMIN) lo_cnt_d = lo_cnt_q + 1'b1;
    else                     lo_cnt_d = lo_cnt_q;

    abt_p_d = do_abort;
    if (do_abort)              abt_cnt_d = ABT_LEN;
    else if (abt_cnt_q != '0)  abt_cnt_d = abt_cnt_q - 1'b1;
    else                       abt_cnt_d = abt_cnt_q;

    inv_d   = inv_q;
    inv_a_d = inv_a_q;
    if (do_abort) begin
      inv_d   = 1'b1;
      inv_a_d = core_op_addr;
    end else if (core_done && abt_cnt_q == '0) begin
      inv_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt_q  <= '0;
      abt_cnt_q <= '0;
      abt_p_q   <= 1'b0;
      inv_q     <= 1'b0;
      inv_a_q   <= '0;
    end else begin
      lo_cnt_q  <= lo_cnt_d;
      abt_cnt_q <= abt_cnt_d;
      abt_p_q   <= abt_p_d;
      inv_q     <= inv_d;
      inv_a_q   <= inv_a_d;
    end
  end

  assign abort_pulse = abt_p_q;
  assign dev_busy    = core_busy | (abt_cnt_q != '0);
  assign inval_flag  = inv_q;
  assign inval_addr  = inv_a_q;
endmodule

// File: rtl/mux_flash_bus_if.sv
module mux_flash_bus_if #(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 8,
  parameter int DATA_W      = 8,
  parameter int RST_MIN_CYC = 4,
  parameter int ABORT_CYC   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_W-1:0]       addr_pin,
  input  logic                   rowcol_sel,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic                   rp_n,
  input  logic [DATA_W-1:0]      dq_in,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_drive,
  output logic [ROW_W+COL_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]      rd_data,
  output logic                   cmd_wr_valid,
  output logic [ROW_W+COL_W-1:0] cmd_wr_addr,
  output logic [DATA_W-1:0]      cmd_wr_data,
  input  logic                   core_busy,
  input  logic                   core_done,
  input  logic [ROW_W+COL_W-1:0] core_op_addr,
  output logic                   abort_pulse,
  output logic                   dev_busy,
  output logic                   inval_flag,
  output logic [ROW_W+COL_W-1:0] inval_addr,
  output logic                   blk_locked
);
  localparam int AW = ROW_W + COL_W;

  logic          srst_n;
  logic          rst_hit;
  logic [AW-1:0] byte_addr;

  mfb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  mfb_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk        (clk),
    .rst_n      (srst_n),
    .rowcol_sel (rowcol_sel),
    .addr_pin   (addr_pin),
    .pin_en     (rp_n),
    .clr        (rst_hit),
    .byte_addr  (byte_addr)
  );

  mfb_cycle_decode #(.AW(AW), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (srst_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .rp_n      (rp_n),
    .dq_in     (dq_in),
    .rd_data   (rd_data),
    .byte_addr (byte_addr),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive),
    .wr_valid  (cmd_wr_valid),
    .wr_addr   (cmd_wr_addr),
    .wr_data   (cmd_wr_data)
  );

  mfb_abort_ctl #(.AW(AW), .RST_MIN_CYC(RST_MIN_CYC), .ABORT_CYC(ABORT_CYC)) u_abort (
    .clk          (clk),
    .rst_n        (srst_n),
    .rp_n         (rp_n),
    .core_busy    (core_busy),
    .core_done    (core_done),
    .core_op_addr (core_op_addr),
    .rst_hit      (rst_hit),
    .abort_pulse  (abort_pulse),
    .dev_busy     (dev_busy),
    .inval_flag   (inval_flag),
    .inval_addr   (inval_addr)
  );

  assign rd_addr    = byte_addr;
  assign blk_locked = 1'b0;
endmodule

// File: rtl/mfb_checker.sv
module mfb_checker #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          rp_n,
  input logic          dq_drive,
  input logic          cmd_wr_valid,
  input logic [AW-1:0] cmd_wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          abort_pulse,
  input logic          dev_busy,
  input logic          inval_flag
);
  AST_HIZ_ON_OE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);                                             // R3
  AST_HIZ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |-> !dq_drive);                                            // R4
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_drive);                                            // R6
  AST_WR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_valid |-> ($past(we_n) && !$past(we_n, 2)));              // R5
  AST_WR_ADDR_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_valid |-> (cmd_wr_addr == $past(rd_addr)));               // R5
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_valid |=> !cmd_wr_valid);                                 // R5
  AST_ABORT_NEEDS_RP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !$past(rp_n));                                   // R7
  AST_ABORT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> dev_busy);                                       // R8
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);                                   // R8
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> inval_flag);                                     // R9
endmodule

bind mux_flash_bus_if mfb_checker #(.AW(ROW_W + COL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .oe_n         (oe_n),
  .we_n         (we_n),
  .rp_n         (rp_n),
  .dq_drive     (dq_drive),
  .cmd_wr_valid (cmd_wr_valid),
  .cmd_wr_addr  (cmd_wr_addr),
  .rd_addr      (rd_addr),
  .abort_pulse  (abort_pulse),
  .dev_busy     (dev_busy),
  .inval_flag   (inval_flag)
);

// File: tb/mux_flash_bus_if_tb.sv
`timescale 1ns/1ps
module mux_flash_bus_if_tb_top;
  localparam int RMIN = 4;
  localparam int ABT  = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr_pin;
  logic        rowcol_sel, oe_n, we_n, rp_n;
  logic [7:0]  dq_in, dq_out, rd_data, cmd_wr_data;
  logic        dq_drive, cmd_wr_valid, core_busy, core_done;
  logic        abort_pulse, dev_busy, inval_flag, blk_locked;
  logic [18:0] rd_addr, cmd_wr_addr, core_op_addr, inval_addr;

  always #2 clk = ~clk;

  mux_flash_bus_if #(.RST_MIN_CYC(RMIN), .ABORT_CYC(ABT)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .rowcol_sel(rowcol_sel),
    .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n), .dq_in(dq_in), .dq_out(dq_out),
    .dq_drive(dq_drive), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_wr_valid(cmd_wr_valid), .cmd_wr_addr(cmd_wr_addr),
    .cmd_wr_data(cmd_wr_data), .core_busy(core_busy), .core_done(core_done),
    .core_op_addr(core_op_addr), .abort_pulse(abort_pulse),
    .dev_busy(dev_busy), .inval_flag(inval_flag), .inval_addr(inval_addr),
    .blk_locked(blk_locked)
  );

  function automatic logic [7:0] mem(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
  endfunction

  assign rd_data = mem(rd_addr);

  // behavioural reference model
  int          n_chk = 0, n_bad = 0, since_rel = 0, cycles = 0;
  logic        m_rcq, m_weq, m_rdq, m_cmdv, m_abtp, m_inv;
  logic [10:0] m_row;
  logic [7:0]  m_col, m_hold, m_dqo, m_cmdd;
  logic [18:0] m_cmda, m_inva;
  int          m_lo, m_acnt;

  task automatic model_reset();
    m_rcq = 1; m_weq = 1; m_rdq = 0; m_cmdv = 0; m_abtp = 0; m_inv = 0;
    m_row = 0; m_col = 0; m_hold = 0; m_dqo = 0; m_cmdd = 0; m_cmda = 0;
    m_inva = 0; m_lo = 0; m_acnt = 0;
  endtask

  task automatic model_edge();
    logic        hit, abt, fall, rise, wrise;
    logic [18:0] a_old;
    if (!rst_n) since_rel = 0; else since_rel++;
    if (since_rel < 3) begin model_reset(); return; end
    a_old = {m_row, m_col};
    hit   = !rp_n && (m_lo == RMIN - 1);
    abt   = hit && core_busy;
    fall  = m_rcq && !rowcol_sel && rp_n;
    rise  = !m_rcq && rowcol_sel && rp_n;
    wrise = !m_weq && we_n && rp_n;
    m_dqo  = mem(a_old);
    m_rdq  = rp_n && we_n && !oe_n;
    m_cmdv = wrise;
    if (wrise) begin m_cmda = a_old; m_cmdd = m_hold; end
    if (rp_n && !we_n) m_hold = dq_in;
    if (hit) begin m_row = 0; m_col = 0; end
    else begin
      if (fall) m_row = addr_pin;
      if (rise) m_col = addr_pin[7:0];
    end
    if (abt) begin m_inv = 1; m_inva = core_op_addr; end
    else if (core_done && m_acnt == 0) m_inv = 0;
    m_abtp = abt;
    if (abt) m_acnt = ABT; else if (m_acnt > 0) m_acnt--;
    m_lo  = rp_n ? 0 : ((m_lo < RMIN) ? m_lo + 1 : m_lo);
    m_rcq = rowcol_sel;
    m_weq = we_n;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    logic  edrv;
    string dreq;
    edrv = m_rdq && rp_n && we_n && !oe_n;
    if (!rp_n)      dreq = "R4 dq_drive";
    else if (!we_n) dreq = "R6 dq_drive";
    else if (oe_n)  dreq = "R3 dq_drive";
    else            dreq = "R2 dq_drive";
    chk(dreq, 32'(dq_drive), 32'(edrv));
    if (edrv) chk("R2 dq_out", 32'(dq_out), 32'(m_dqo));
    chk("R1 R12 rd_addr", 32'(rd_addr), 32'({m_row, m_col}));
    chk("R5 cmd_wr_valid", 32'(cmd_wr_valid), 32'(m_cmdv));
    if (m_cmdv) begin
      chk("R5 cmd_wr_addr", 32'(cmd_wr_addr), 32'(m_cmda));
      chk("R5 cmd_wr_data", 32'(cmd_wr_data), 32'(m_cmdd));
    end
    chk("R7 R12 abort_pulse", 32'(abort_pulse), 32'(m_abtp));
    chk("R8 dev_busy", 32'(dev_busy), 32'(core_busy || m_acnt != 0));
    chk("R9 R10 inval_flag", 32'(inval_flag), 32'(m_inv));
    if (m_inv) chk("R9 inval_addr", 32'(inval_addr), 32'(m_inva));
    chk("R11 blk_locked", 32'(blk_locked), 32'(0));
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_edge();
      @(negedge clk); compare();
    end
  endtask

  task automatic latch_addr(input logic [10:0] row, input logic [7:0] col);
    addr_pin = row; rowcol_sel = 0; step();
    addr_pin = {3'd0, col}; rowcol_sel = 1; step();
  endtask

  task automatic do_read();
    oe_n = 0; step(3); oe_n = 1; step();
  endtask

  task automatic do_write(input logic [7:0] d);
    dq_in = d; we_n = 0; step(2); we_n = 1; step(2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; addr_pin = 0; rowcol_sel = 1; oe_n = 1; we_n = 1; rp_n = 1;
    dq_in = 0; core_busy = 0; core_done = 0; core_op_addr = 0;
    model_reset();
    step(3);
    rst_n = 1;
    step(4);
    // R1 R2: several addresses and reads
    latch_addr(11'h7FF, 8'hA5); do_read();
    latch_addr(11'h123, 8'h00); do_read();
    latch_addr(11'h000, 8'hFF); do_read();
    // R3: output disable in the middle of a read
    oe_n = 0; step(2); oe_n = 1; step(); oe_n = 0; step(2); oe_n = 1; step();
    // R5 R11: writes of arbitrary commands
    do_write(8'h60); do_write(8'h01); do_write(8'hD0);
    // R6: both enables low
    oe_n = 0; dq_in = 8'h3C; we_n = 0; step(3); we_n = 1; step(); oe_n = 1; step();
    // coincidence: we_n rise with row strobe fall
    dq_in = 8'h77; we_n = 0; step(2);
    we_n = 1; addr_pin = 11'h456; rowcol_sel = 0; step();
    addr_pin = 11'h0BE; rowcol_sel = 1; step(2);
    // R7: short reset pulse while busy has no effect
    core_busy = 1; core_op_addr = 19'h1ABCD;
    rp_n = 0; step(RMIN - 1); rp_n = 1; step(3);
    // R4 R8 R9: valid reset while busy
    oe_n = 0; rp_n = 0; step(RMIN + 2); rp_n = 1; core_busy = 0; step(ABT + 3);
    oe_n = 1; step();
    // R10: successful completion clears flag
    latch_addr(11'h055, 8'h66);
    core_done = 1; step(); core_done = 0; step(2);
    // coincidence: done with abort at same edge, set wins
    core_busy = 1; core_op_addr = 19'h00F0F;
    rp_n = 0; step(RMIN - 1); core_done = 1; step(); core_done = 0;
    rp_n = 1; core_busy = 0; step(4);
    // R10: done during abort time ignored, then honoured
    core_done = 1; step(); core_done = 0; step(ABT);
    core_done = 1; step(); core_done = 0; step(2);
    // R12: valid reset without busy clears address, no abort
    latch_addr(11'h3AA, 8'h5C);
    rp_n = 0; step(RMIN + 1); rp_n = 1; step(3);
    do_read();
    finish_run();
  end
endmodule